// File: doc/BRIEF.md
# Escalating Watchdog with Configuration Lock

This block watches for a stalled system. A down-counter runs from a value held in a programmable load register. When the count expires the first time, the block raises an interrupt and starts a new period. Software services the watchdog by clearing that interrupt, which also restarts the count. If the interrupt is still pending when the count expires again, and reset escalation is enabled, the block raises a reset request. That request stays high until the next system reset.

After software has set the block up, it can write to a lock register. While the block is locked, writes to the load and control registers have no effect. Clearing the interrupt still works while locked. Writing the unlock key (`32'h5AFE_C0DE`) releases the lock. Writing any other value sets it. All register access goes through a single-cycle write port and a combinational read port.

Top module: `wdt_escalator`

## Requirements
- R1: After reset, `irq` and `rst_req` are 0. The register reads are: LOAD (addr 0) = `32'hFFFF_FFFF`, CTRL (addr 1) = 0, LOCK (addr 3) = 0, STATUS (addr 5) = 0, VALUE (addr 4) = `32'hFFFF_FFFF`.
- R2: The counter holds its value while the interrupt enable (CTRL bit 0) is 0. The write that sets this enable loads the counter from LOAD at that same edge. After that, VALUE drops by 1 on every clock.
- R3: On the clock after VALUE reads 0, the counter reloads from LOAD and `irq` rises. STATUS bit 0 reads the pending interrupt. One period is therefore LOAD+1 cycles.
- R4: A time-out that occurs while `irq` is already pending, with reset enable (CTRL bit 1) set, raises `rst_req`. `rst_req` stays high, even after a clear, until `rst_n` is asserted.
- R5: With reset enable at 0, a second time-out leaves `rst_req` at 0 and `irq` at 1.
- R6: A write of any data to CLEAR (addr 2) drops `irq` and reloads the counter from LOAD at that edge.
- R7: A write of `32'h5AFE_C0DE` to LOCK unlocks the block. A write of any other value to LOCK locks it. LOCK reads 1 while locked and 0 while unlocked.
- R8: While locked, writes to LOAD and CTRL do not change those registers. CLEAR writes still take effect.
- R9: Once the interrupt enable is set, a CTRL write with bit 0 at 0 leaves it set.
- R10: An unlocked write to LOAD updates LOAD and reloads the counter with the new value at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe, acted on at the rising clock edge |
| bus_addr | input | 3 | Register select: 0 LOAD, 1 CTRL, 2 CLEAR, 3 LOCK, 4 VALUE, 5 STATUS |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` (CLEAR and unused addresses read 0) |
| irq | output | 1 | Pending time-out interrupt |
| rst_req | output | 1 | Sticky reset request |

## Verification
Every write takes effect at the edge that samples it. A read reflects that write about half a cycle later, and `irq` and `rst_req` move on the same edge as the change that causes them. The counter leaves 0 and `irq` rises one edge after VALUE reads 0. The bench therefore counts edges from the write that starts or reloads the counter: it expects the first time-out at edge L+1 and the second at edge 2(L+1). The driver changes inputs 2 ns after a rising edge and queues its expectations. The monitor compares them at the next falling edge. Each expectation whose value depends on time is queued within the single cycle it names.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_LOAD   = 3'd0,
    REG_CTRL   = 3'd1,
    REG_CLEAR  = 3'd2,
    REG_LOCK   = 3'd3,
    REG_VALUE  = 3'd4,
    REG_STATUS = 3'd5
  } wdt_reg_e;

  localparam int unsigned CTRL_IRQ_EN = 0;
  localparam int unsigned CTRL_RST_EN = 1;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
#(
  parameter int unsigned      DATA_W   = 32,
  parameter logic [DATA_W-1:0] LOAD_RST = '1,
  parameter logic [DATA_W-1:0] KEY      = 32'h5AFE_C0DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_q,
  output logic              irq_en_q,
  output logic              rst_en_q,
  output logic              locked_q,
  output logic              clear_req,
  output logic              reload_req,
  output logic [DATA_W-1:0] reload_val
);
  logic              cfg_ok;
  logic              sel_load, sel_ctrl, sel_clear, sel_lock;
  logic [DATA_W-1:0] load_d;
  logic              irq_en_d, rst_en_d, locked_d;

  always_comb begin
    sel_load  = (addr == REG_LOAD);
    sel_ctrl  = (addr == REG_CTRL);
    sel_clear = (addr == REG_CLEAR);
    sel_lock  = (addr == REG_LOCK);
    cfg_ok    = wr_en && !locked_q;

    load_d   = (cfg_ok && sel_load) ? wdata : load_q;
    irq_en_d = irq_en_q | (cfg_ok && sel_ctrl && wdata[CTRL_IRQ_EN]);
    rst_en_d = (cfg_ok && sel_ctrl) ? wdata[CTRL_RST_EN] : rst_en_q;
    locked_d = (wr_en && sel_lock) ? (wdata != KEY) : locked_q;

    clear_req  = wr_en && sel_clear;
    reload_req = clear_req || (cfg_ok && sel_load) || (irq_en_d && !irq_en_q);
    reload_val = load_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= LOAD_RST;
      irq_en_q <= 1'b0;
      rst_en_q <= 1'b0;
      locked_q <= 1'b0;
    end else if (wr_en) begin
      load_q   <= load_d;
      irq_en_q <= irq_en_d;
      rst_en_q <= rst_en_d;
      locked_q <= locked_d;
    end
  end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int unsigned       DATA_W = 32,
  parameter logic [DATA_W-1:0] INIT   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              reload,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] cnt_q,
  output logic              expire
);
  logic [DATA_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    expire = run && !reload && (cnt_q == '0);
    cnt_en = reload || run;
    if (reload || expire) cnt_d = reload_val;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= INIT;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clear,
  input  logic rst_en,
  output logic irq_q,
  output logic rst_q
);
  logic irq_d, rst_d, upd_en;

  always_comb begin
    upd_en = expire || clear;
    irq_d  = clear ? 1'b0 : 1'b1;
    rst_d  = rst_q || (expire && irq_q && rst_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else if (upd_en) begin
      irq_q <= irq_d;
      rst_q <= rst_d;
    end
  end
endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
  import wdt_pkg::*;
#(
  parameter int unsigned       DATA_W      = 32,
  parameter logic [DATA_W-1:0] LOAD_RST    = '1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY  = 32'h5AFE_C0DE,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  logic              rst_n_int;
  logic [DATA_W-1:0] load_q, reload_val, cnt_q;
  logic              irq_en_q, rst_en_q, locked_q;
  logic              clear_req, reload_req, expire;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_int)
  );

  wdt_cfg_regs #(.DATA_W(DATA_W), .LOAD_RST(LOAD_RST), .KEY(UNLOCK_KEY)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .load_q(load_q), .irq_en_q(irq_en_q),
    .rst_en_q(rst_en_q), .locked_q(locked_q), .clear_req(clear_req),
    .reload_req(reload_req), .reload_val(reload_val)
  );

  wdt_down_counter #(.DATA_W(DATA_W), .INIT(LOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .run(irq_en_q), .reload(reload_req),
    .reload_val(reload_val), .cnt_q(cnt_q), .expire(expire)
  );

  wdt_escalate u_esc (
    .clk(clk), .rst_n(rst_n_int), .expire(expire), .clear(clear_req),
    .rst_en(rst_en_q), .irq_q(irq), .rst_q(rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_LOAD:   bus_rdata = load_q;
      REG_CTRL: begin
        bus_rdata[CTRL_IRQ_EN] = irq_en_q;
        bus_rdata[CTRL_RST_EN] = rst_en_q;
      end
      REG_LOCK:   bus_rdata[0] = locked_q;
      REG_VALUE:  bus_rdata = cnt_q;
      REG_STATUS: bus_rdata[0] = irq;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_escalator_chk.sv
module wdt_escalator_chk
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic              rst_req,
  input logic              locked,
  input logic [DATA_W-1:0] load_q,
  input logic              irq_en,
  input logic [DATA_W-1:0] cnt,
  input logic              reload
);
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !reload && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_expire_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !reload && cnt == '0) |=> irq);

  p_rst_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  p_rst_after_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(irq));

  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_CLEAR) |=> !irq);

  p_locked_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_wr && bus_addr == REG_LOAD) |=> $stable(load_q));

  p_enable_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en |=> irq_en);
endmodule

bind wdt_escalator wdt_escalator_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .irq(irq), .rst_req(rst_req), .locked(locked_q), .load_q(load_q),
  .irq_en(irq_en_q), .cnt(cnt_q), .reload(reload_req)
);

// File: tb/test_wdt_escalator.sv
module test_wdt_escalator;
  localparam logic [31:0] KEY = 32'h5AFE_C0DE;
  localparam logic [2:0] A_LOAD = 3'd0, A_CTRL = 3'd1, A_CLEAR = 3'd2,
                         A_LOCK = 3'd3, A_VALUE = 3'd4, A_STATUS = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 rst_req
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  wdt_escalator i_wdt_escalator (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  // Monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {31'b0, irq};
        default: act = {31'b0, rst_req};
      endcase
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic chk_pin(input int kind, input logic exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = {31'b0, exp}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    bus_addr = a;
    it.kind = 0; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    chk_pin(1, 1'b0, "R1 irq");
    chk_pin(2, 1'b0, "R1 rst_req");
    chk_rd(A_LOCK, 32'h0, "R1 lock");
    chk_rd(A_LOAD, 32'hFFFF_FFFF, "R1 load");
    chk_rd(A_CTRL, 32'h0, "R1 ctrl");
    chk_rd(A_STATUS, 32'h0, "R1 status");
    chk_rd(A_VALUE, 32'hFFFF_FFFF, "R1 value");
    tick(5);
    chk_rd(A_VALUE, 32'hFFFF_FFFF, "R2 holds while disabled");

    // R10 load write while disabled reloads; R2 enable starts count
    wr(A_LOAD, 32'd10);
    chk_rd(A_VALUE, 32'd10, "R10 load reloads");
    wr(A_CTRL, 32'h1);                       // edge E0: cnt = 10
    chk_rd(A_VALUE, 32'd10, "R2 enable loads");
    tick(3);
    chk_rd(A_VALUE, 32'd7, "R2 decrement");
    tick(7);                                  // E10
    chk_pin(1, 1'b0, "R3 no irq at zero");
    chk_rd(A_VALUE, 32'd0, "R3 value zero");
    tick(1);                                  // E11
    chk_pin(1, 1'b1, "R3 irq at timeout");
    chk_rd(A_VALUE, 32'd10, "R3 reload");
    chk_rd(A_STATUS, 32'h1, "R3 status pending");

    // R6 clear
    wr(A_CLEAR, 32'h1234);                    // F0
    chk_pin(1, 1'b0, "R6 irq cleared");
    chk_rd(A_VALUE, 32'd10, "R6 clear reloads");
    tick(11);                                 // F11
    chk_pin(1, 1'b1, "R5 first timeout");
    tick(11);                                 // F22
    chk_pin(2, 1'b0, "R5 no reset when disabled");
    chk_pin(1, 1'b1, "R5 irq stays");
    chk_rd(A_VALUE, 32'd10, "R5 reload second");

    // R9 enable sticky
    wr(A_CTRL, 32'h0);
    chk_rd(A_CTRL, 32'h1, "R9 enable sticky");

    // R7 / R8 lock
    wr(A_CLEAR, 32'h0);
    wr(A_LOCK, 32'h5);
    chk_rd(A_LOCK, 32'h1, "R7 lock by other value");
    wr(A_LOAD, 32'd3);
    chk_rd(A_LOAD, 32'd10, "R8 load ignored when locked");
    wr(A_CTRL, 32'h3);
    chk_rd(A_CTRL, 32'h1, "R8 ctrl ignored when locked");
    wr(A_CLEAR, 32'h0);
    chk_pin(1, 1'b0, "R8 clear works when locked");
    chk_rd(A_VALUE, 32'd10, "R8 clear reload when locked");
    wr(A_LOCK, KEY);
    chk_rd(A_LOCK, 32'h0, "R7 key unlocks");
    wr(A_LOCK, 32'h0);
    chk_rd(A_LOCK, 32'h1, "R7 zero locks");
    wr(A_LOCK, KEY);
    chk_rd(A_LOCK, 32'h0, "R7 key unlocks again");

    // R4 escalation
    wr(A_CLEAR, 32'h0);
    wr(A_LOAD, 32'd4);                        // G0: cnt = 4
    wr(A_CTRL, 32'h3);                        // G1: cnt = 3
    chk_rd(A_VALUE, 32'd3, "R10 new load value counted");
    tick(3);                                  // G4
    chk_pin(1, 1'b0, "R4 before first timeout");
    chk_rd(A_VALUE, 32'd0, "R4 value zero");
    tick(1);                                  // G5
    chk_pin(1, 1'b1, "R4 first timeout irq");
    chk_pin(2, 1'b0, "R4 no reset on first");
    tick(4);                                  // G9
    chk_pin(2, 1'b0, "R4 no reset before second");
    tick(1);                                  // G10
    chk_pin(2, 1'b1, "R4 reset on second timeout");
    wr(A_CLEAR, 32'h0);
    chk_pin(1, 1'b0, "R6 clear after escalation");
    chk_pin(2, 1'b1, "R4 reset survives clear");
    tick(20);
    chk_pin(2, 1'b1, "R4 reset sticky");
    chk_rd(A_LOAD, 32'd4, "R10 load value");

    // R1 reset again
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(3);
    chk_pin(2, 1'b0, "R1 rst_req after reset");
    chk_pin(1, 1'b0, "R1 irq after reset");
    chk_rd(A_CTRL, 32'h0, "R1 ctrl after reset");
    chk_rd(A_LOAD, 32'hFFFF_FFFF, "R1 load after reset");

    tick(2);
    done = 1'b1;
    report();
  end
endmodule